// File: doc/BRIEF.md
# Flash Sector Map with Boot Lock

This block sits beside the command sequencer of a flash memory model. Every word address is placed in one of four erase sectors, laid out with the boot sector at the bottom of the address space. The block holds a one-way boot-lock flag and judges each program, sector-erase and chip-erase request. It answers with a one-cycle grant or reject pulse, and with the set of sectors an erase is allowed to clear.

The sequencer raises a request strobe for one cycle, with the target word address on `addr`. On the following cycle it reads `grant` or `reject`. A reject lets it go straight back to read mode without starting an operation timer. The `hv_override` input stands for the high-voltage reset condition. While it is held, the lock is bypassed. Identification reads at the lock-status offset return the lock flag on `id_lock_bit`.

Top module: `flash_sector_guard`

## Requirements
- R1: `sector_sel` is one-hot and combinational from `addr`. Bit 0 is boot (0x00000–0x01FFF), bit 1 is parameter A (0x02000–0x02FFF), bit 2 is parameter B (0x03000–0x03FFF) and bit 3 is main (0x04000–0x7FFFF).
- R2: The boot lock is clear after reset and becomes set one cycle after `lock_set` is sampled high. Only `rst_n` clears it again.
- R3: Suppose the lock is set and `hv_override` is low. A program or sector-erase request to the boot sector then gives `reject`=1, `grant`=0 and `erase_mask`=0 on the next cycle.
- R4: A chip erase is always granted. Its `erase_mask` is 4'b1110 (boot kept) when the lock is set and override is low, and 4'b1111 otherwise.
- R5: With `hv_override` high, boot-sector program and erase requests are granted despite the lock. Once `hv_override` drops, the lock refuses them again.
- R6: A request to a non-boot sector is always granted. A granted sector erase carries `erase_mask` equal to the target's `sector_sel`. A granted program carries `erase_mask`=0.
- R7: `id_lock_bit` equals the lock flag when `id_read` is high and `addr` is 0x00002. It is 0 in all other cases.
- R8: `grant` and `reject` are single-cycle pulses, registered one cycle after the request, and never both high. When several requests are high together, chip erase wins over sector erase, and sector erase wins over program.
- R9: A request sampled in the same cycle as `lock_set` is judged with the lock state from before that cycle.
- R10: After reset, `grant`, `reject` and `erase_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the only way to clear the lock |
| addr | input | 19 | Word address of the request or identification read |
| prog_req | input | 1 | Program request strobe |
| serase_req | input | 1 | Sector-erase request strobe |
| cerase_req | input | 1 | Chip-erase request strobe |
| lock_set | input | 1 | Sets the boot lock (sequence already decoded) |
| hv_override | input | 1 | High-voltage override of the lock |
| id_read | input | 1 | Identification-mode read qualifier |
| sector_sel | output | 4 | One-hot sector of `addr` |
| grant | output | 1 | Request permitted (pulse) |
| reject | output | 1 | Request refused (pulse) |
| erase_mask | output | 4 | Sectors the granted erase may clear |
| id_lock_bit | output | 1 | Lock state at the identification offset |

## Verification
The lock being set and a boot-sector request being judged can fall in the same cycle. The bench provokes this by raising `lock_set` together with a boot program request. It expects a grant, because the old lock state applies. The very next boot request must then be rejected. A second collision raises program and chip erase together at a boot address while locked. That case is judged by the chip-erase mask of 4'b1110 with a grant and no reject.

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
  parameter int AW          = 19,
  parameter int BOOT_AW     = 13,
  parameter int PARAM_AW    = 12,
  parameter int ID_LOCK_OFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          prog_req,
  input  logic          serase_req,
  input  logic          cerase_req,
  input  logic          lock_set,
  input  logic          hv_override,
  input  logic          id_read,
  output logic [3:0]    sector_sel,
  output logic          grant,
  output logic          reject,
  output logic [3:0]    erase_mask,
  output logic          id_lock_bit
);

  localparam logic [AW-1:0] PA_BASE   = AW'(1) << BOOT_AW;
  localparam logic [AW-1:0] PB_BASE   = PA_BASE + (AW'(1) << PARAM_AW);
  localparam logic [AW-1:0] MAIN_BASE = PB_BASE + (AW'(1) << PARAM_AW);
  localparam logic [3:0]    ALL_SECT  = 4'b1111;
  localparam logic [3:0]    BOOT_SECT = 4'b0001;

  logic locked;
  logic guard;
  logic boot_blocked;

  assign sector_sel[0] = addr < PA_BASE;
  assign sector_sel[1] = (addr >= PA_BASE) && (addr < PB_BASE);
  assign sector_sel[2] = (addr >= PB_BASE) && (addr < MAIN_BASE);
  assign sector_sel[3] = addr >= MAIN_BASE;

  assign guard        = locked & ~hv_override;
  assign boot_blocked = guard & sector_sel[0];

  assign id_lock_bit = id_read && (addr == AW'(ID_LOCK_OFS)) && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      grant      <= 1'b0;
      reject     <= 1'b0;
      erase_mask <= '0;
    end else begin
      if (lock_set) locked <= 1'b1;
      grant      <= 1'b0;
      reject     <= 1'b0;
      erase_mask <= '0;
      if (cerase_req) begin
        grant      <= 1'b1;
        erase_mask <= guard ? (ALL_SECT & ~BOOT_SECT) : ALL_SECT;
      end else if (serase_req) begin
        if (boot_blocked) begin
          reject <= 1'b1;
        end else begin
          grant      <= 1'b1;
          erase_mask <= sector_sel;
        end
      end else if (prog_req) begin
        if (boot_blocked) reject <= 1'b1;
        else              grant  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_sector_guard_chk.sv
module flash_sector_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_req,
  input logic       serase_req,
  input logic       cerase_req,
  input logic       lock_set,
  input logic       hv_override,
  input logic [3:0] sector_sel,
  input logic       locked,
  input logic       grant,
  input logic       reject,
  input logic [3:0] erase_mask
);

  a_r1_sector_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sector_sel) == 1);

  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r2_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked);

  a_r3_boot_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || serase_req) && !cerase_req && sector_sel[0] && locked && !hv_override
    |=> reject && !grant && erase_mask == 4'b0000);

  a_r4_chip_keeps_boot: assert property (@(posedge clk) disable iff (!rst_n)
    cerase_req && locked && !hv_override |=> grant && erase_mask == 4'b1110);

  a_r5_override_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || serase_req || cerase_req) && hv_override |=> grant && !reject);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req && !serase_req && !cerase_req |=> !grant && !reject && erase_mask == 4'b0000);

endmodule

bind flash_sector_guard flash_sector_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .serase_req(serase_req),
  .cerase_req(cerase_req), .lock_set(lock_set), .hv_override(hv_override),
  .sector_sel(sector_sel), .locked(locked), .grant(grant), .reject(reject),
  .erase_mask(erase_mask)
);

// File: tb/tb_flash_sector_guard.sv
module tb_flash_sector_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] addr = '0;
  logic        prog_req = 0, serase_req = 0, cerase_req = 0;
  logic        lock_set = 0, hv_override = 0, id_read = 0;
  logic [3:0]  sector_sel, erase_mask;
  logic        grant, reject, id_lock_bit;
  int          nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  flash_sector_guard dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .prog_req(prog_req),
    .serase_req(serase_req), .cerase_req(cerase_req), .lock_set(lock_set),
    .hv_override(hv_override), .id_read(id_read), .sector_sel(sector_sel),
    .grant(grant), .reject(reject), .erase_mask(erase_mask),
    .id_lock_bit(id_lock_bit)
  );

  // {addr, prog, serase, cerase, lock_set, ovr, exp_grant, exp_reject, exp_mask, exp_sel, req}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {19'h00010, 5'b10000, 2'b10, 4'b0000, 4'b0001, 4'd6},  // R6 unlocked boot program
    {19'h02100, 5'b01000, 2'b10, 4'b0010, 4'b0010, 4'd6},  // R6
    {19'h03FFF, 5'b01000, 2'b10, 4'b0100, 4'b0100, 4'd1},  // R1 edge
    {19'h04000, 5'b01000, 2'b10, 4'b1000, 4'b1000, 4'd1},  // R1 edge
    {19'h7FFFF, 5'b00100, 2'b10, 4'b1111, 4'b1000, 4'd4},  // R4 unlocked
    {19'h01FFF, 5'b10010, 2'b10, 4'b0000, 4'b0001, 4'd9},  // R9 lock same cycle
    {19'h01FFF, 5'b10000, 2'b01, 4'b0000, 4'b0001, 4'd3},  // R3
    {19'h00000, 5'b01000, 2'b01, 4'b0000, 4'b0001, 4'd3},  // R3
    {19'h00000, 5'b01001, 2'b10, 4'b0001, 4'b0001, 4'd5},  // R5
    {19'h01000, 5'b10001, 2'b10, 4'b0000, 4'b0001, 4'd5},  // R5
    {19'h12345, 5'b00100, 2'b10, 4'b1110, 4'b1000, 4'd4},  // R4 locked
    {19'h12345, 5'b00101, 2'b10, 4'b1111, 4'b1000, 4'd5},  // R5 chip with override
    {19'h02000, 5'b10000, 2'b10, 4'b0000, 4'b0010, 4'd6},  // R6 locked, non-boot
    {19'h7FFFF, 5'b01000, 2'b10, 4'b1000, 4'b1000, 4'd6},  // R6
    {19'h02FFF, 5'b00010, 2'b00, 4'b0000, 4'b0010, 4'd8},  // R8 no request
    {19'h00005, 5'b10100, 2'b10, 4'b1110, 4'b0001, 4'd8}   // R8 priority chip over program
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    prog_req = 0; serase_req = 0; cerase_req = 0; lock_set = 0; hv_override = 0; id_read = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check("R10", {6'd0, grant, reject}, 8'd0);
    check("R10", {4'd0, erase_mask}, 8'd0);
    @(negedge clk); rst_n = 1;
    id_read = 1; addr = 19'h00002; #2;
    check("R2", {7'd0, id_lock_bit}, 8'd0);
    idle();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][37:19];
      prog_req = VEC[i][18]; serase_req = VEC[i][17]; cerase_req = VEC[i][16];
      lock_set = VEC[i][15]; hv_override = VEC[i][14];
      #2;
      check($sformatf("R1 vec%0d", i), {4'd0, sector_sel}, {4'd0, VEC[i][7:4]});
      @(posedge clk); #2;
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {6'd0, grant, reject},
            {6'd0, VEC[i][13], VEC[i][12]});
      check($sformatf("R%0d vec%0d mask", VEC[i][3:0], i), {4'd0, erase_mask},
            {4'd0, VEC[i][11:8]});
      @(negedge clk); idle();
    end

    // R8 pulse ends after one cycle
    @(posedge clk); #2;
    check("R8", {6'd0, grant, reject}, 8'd0);

    // R7 identification reads while locked
    @(negedge clk); id_read = 1; addr = 19'h00002; #2;
    check("R7", {7'd0, id_lock_bit}, 8'd1);
    addr = 19'h00003; #2;
    check("R7", {7'd0, id_lock_bit}, 8'd0);
    addr = 19'h00002; id_read = 0; #2;
    check("R7", {7'd0, id_lock_bit}, 8'd0);

    // R5 lock returns after override released
    @(negedge clk); idle(); addr = 19'h00100; serase_req = 1;
    @(posedge clk); #2;
    check("R5", {6'd0, grant, reject}, 8'd1);

    // R2 only reset clears the lock
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1; id_read = 1; addr = 19'h00002; #2;
    check("R2", {7'd0, id_lock_bit}, 8'd0);
    id_read = 0; addr = 19'h00100; prog_req = 1;
    @(posedge clk); #2;
    check("R2", {6'd0, grant, reject}, 8'd2);
    @(negedge clk); idle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule